// File: doc/BRIEF.md
# Tone Detect Output Formatter

This block turns the raw tone-present flag of each of two detector channels into the channel's digital output pin. Both channels share one format control. In tone-follower format a pin copies the channel's detection flag one clock later. In packet format a pin rises only once enough ticks of tone have collected inside a fixed observation window. It falls only once enough ticks of silence have collected inside a fresh window. Short dropouts and short bursts are absorbed because the block integrates over the window and does not demand a continuous run.

A shared active-high high-impedance control releases both pins so several devices can share one line. Time is measured by a one-clock tick pulse, nominally every 1 ms, that the surrounding chip supplies. Each channel keeps a window counter and an accumulator. Both are cleared whenever the format control changes.

Top module: `tone_out_fmt`

## Requirements
- R1: While reset is applied and after its release, with no tone, every packet state is not-asserted and every driven pin is low.
- R2: With `fmt_follow` = 1 and the pins driven, `det_out[i]` equals the value `tone_raw[i]` had at the previous rising clock edge.
- R3: With `fmt_follow` = 0, an idle channel's pin goes high at the tick on which its count of tone ticks in the current window reaches 30.
- R4: Tone ticks need not be consecutive: 30 tone ticks spread over fewer than 40 ticks of one window, with gaps between them, assert the pin.
- R5: A window spans 40 ticks. If the threshold is not reached by the 40th tick, both the window and the count restart from zero. Tone counted in the old window does not carry over.
- R6: An asserted channel in packet format goes low at the tick on which its count of no-tone ticks in the current window reaches 30.
- R7: In packet format, clock cycles without `tick` leave every pin unchanged, whatever `tone_raw` does.
- R8: Any change of `fmt_follow` clears the packet state and counters of both channels to not-asserted.
- R9: With `out_hiz` = 1, `det_drv` is all zero and the pins are high-impedance in the same cycle. With `out_hiz` = 0, `det_drv` is all ones and the pins are driven.
- R10: Channels are independent: one channel's tone has no effect on the other channel's pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle timing pulse (nominally 1 ms) |
| tone_raw | input | NCH | Raw tone-present flag per channel |
| fmt_follow | input | 1 | 1 = tone-follower format, 0 = packet format |
| out_hiz | input | 1 | 1 = release all output pins |
| det_drv | output | NCH | Drive enable per pin (1 = driven) |
| det_out | output | NCH | Tri-state output pin per channel |

## Verification
In follower format the bench applies every two-channel tone combination, with and without release. This separates a correct one-cycle copy from swapped channels or a stuck drive. In packet format it uses a solid tone run that stops one tick short of the threshold and then reaches it, and a gapped pattern of three tone ticks in every four. A pattern that misses the threshold by one tick and is followed by silence shows whether the window restarts or keeps counting. Silence runs show release, idle clocks without ticks show that counting holds, and format toggles taken mid-count show that the state clears.

// File: rtl/tfmt_pkg.sv
package tfmt_pkg;
  typedef enum logic {
    PK_IDLE = 1'b0,
    PK_ON   = 1'b1
  } pk_state_e;
endpackage

// File: rtl/tfmt_rst_sync.sv
module tfmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/tfmt_pkt_chan.sv
module tfmt_pkt_chan
  import tfmt_pkg::*;
#(
  parameter int WIN_TICKS = 40,
  parameter int ON_THR    = 30,
  parameter int OFF_THR   = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tone,
  input  logic clr,
  output logic on
);
  localparam int CW = $clog2(WIN_TICKS + 1);

  pk_state_e     st_q, st_d;
  logic [CW-1:0] win_q, win_d;
  logic [CW-1:0] acc_q, acc_d;
  logic [CW-1:0] win_inc, acc_inc, thr;
  logic          hit;

  always_comb begin
    hit     = (st_q == PK_IDLE) ? tone : !tone;
    win_inc = win_q + CW'(1);
    acc_inc = acc_q + {{(CW-1){1'b0}}, hit};
    thr     = (st_q == PK_IDLE) ? CW'(ON_THR) : CW'(OFF_THR);
    st_d    = st_q;
    win_d   = win_q;
    acc_d   = acc_q;
    if (clr) begin
      st_d  = PK_IDLE;
      win_d = '0;
      acc_d = '0;
    end else if (tick) begin
      if (acc_inc >= thr) begin
        st_d  = (st_q == PK_IDLE) ? PK_ON : PK_IDLE;
        win_d = '0;
        acc_d = '0;
      end else if (win_inc >= CW'(WIN_TICKS)) begin
        win_d = '0;
        acc_d = '0;
      end else begin
        win_d = win_inc;
        acc_d = acc_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PK_IDLE;
      win_q <= '0;
      acc_q <= '0;
    end else if (clr || tick) begin
      st_q  <= st_d;
      win_q <= win_d;
      acc_q <= acc_d;
    end
  end

  assign on = (st_q == PK_ON);
endmodule

// File: rtl/tfmt_out_mux.sv
module tfmt_out_mux #(
  parameter int NCH = 2
) (
  input  logic           follow,
  input  logic           hiz,
  input  logic [NCH-1:0] tone_q,
  input  logic [NCH-1:0] pkt_on,
  output logic [NCH-1:0] val,
  output logic [NCH-1:0] drv
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_comb begin
      val[g] = follow ? tone_q[g] : pkt_on[g];
      drv[g] = !hiz;
    end
  end
endmodule

// File: rtl/tone_out_fmt.sv
module tone_out_fmt #(
  parameter int NCH       = 2,
  parameter int WIN_TICKS = 40,
  parameter int ON_THR    = 30,
  parameter int OFF_THR   = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] tone_raw,
  input  logic           fmt_follow,
  input  logic           out_hiz,
  output logic [NCH-1:0] det_drv,
  output wire  [NCH-1:0] det_out
);
  logic           rst_q_n;
  logic           fmt_q;
  logic           fmt_chg;
  logic [NCH-1:0] tone_q;
  logic [NCH-1:0] pkt_on;
  logic [NCH-1:0] det_val;

  tfmt_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fmt_q  <= 1'b1;
      tone_q <= '0;
    end else begin
      fmt_q  <= fmt_follow;
      tone_q <= tone_raw;
    end
  end

  assign fmt_chg = (fmt_follow != fmt_q);

  for (genvar g = 0; g < NCH; g++) begin : g_pkt
    tfmt_pkt_chan #(
      .WIN_TICKS(WIN_TICKS),
      .ON_THR   (ON_THR),
      .OFF_THR  (OFF_THR)
    ) u_pkt (
      .clk  (clk),
      .rst_n(rst_q_n),
      .tick (tick),
      .tone (tone_raw[g]),
      .clr  (fmt_chg),
      .on   (pkt_on[g])
    );
  end

  tfmt_out_mux #(.NCH(NCH)) u_mux (
    .follow(fmt_follow),
    .hiz   (out_hiz),
    .tone_q(tone_q),
    .pkt_on(pkt_on),
    .val   (det_val),
    .drv   (det_drv)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_pin
    assign det_out[g] = det_drv[g] ? det_val[g] : 1'bz;
  end
endmodule

// File: rtl/tfmt_chk.sv
module tfmt_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           fmt_follow,
  input logic           fmt_q,
  input logic           out_hiz,
  input logic [NCH-1:0] tone_raw,
  input logic [NCH-1:0] pkt_on,
  input logic [NCH-1:0] det_drv,
  input logic [NCH-1:0] det_out
);
  // R9
  hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hiz |-> (det_drv == '0));

  // R9
  drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_hiz |-> (det_drv == {NCH{1'b1}}));

  // R2
  follow_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_follow && fmt_q && !out_hiz && $past(rst_n)) |-> (det_out == $past(tone_raw)));

  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && (fmt_follow == fmt_q)) |=> $stable(pkt_on));

  // R8
  fmt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_follow != fmt_q) |=> (pkt_on == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_edge
    // R3
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pkt_on[g]) |-> $past(tick));
    // R6
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pkt_on[g]) |-> ($past(tick) || $past(fmt_follow != fmt_q)));
  end
endmodule

bind tone_out_fmt tfmt_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .tick      (tick),
  .fmt_follow(fmt_follow),
  .fmt_q     (fmt_q),
  .out_hiz   (out_hiz),
  .tone_raw  (tone_raw),
  .pkt_on    (pkt_on),
  .det_drv   (det_drv),
  .det_out   (det_out)
);

// File: tb/sim_tone_out_fmt.sv
`timescale 1ns/1ps
module sim_tone_out_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] tone_raw = 2'b00;
  logic       fmt_follow = 1'b1;
  logic       out_hiz = 1'b0;
  logic [1:0] det_drv;
  wire  [1:0] det_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tone_out_fmt u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .tone_raw  (tone_raw),
    .fmt_follow(fmt_follow),
    .out_hiz   (out_hiz),
    .det_drv   (det_drv),
    .det_out   (det_out)
  );

  // {fmt_follow, out_hiz, tone_raw, expected det_out, expected det_drv}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    8'b1_0_01_01_11, 8'b1_0_10_10_11, 8'b1_0_11_11_11, 8'b1_0_00_00_11,
    8'b1_1_11_00_00, 8'b1_0_11_11_11, 8'b1_1_00_00_00, 8'b1_0_10_10_11
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] tn, input logic tk);
    @(negedge clk);
    tone_raw = tn;
    tick = tk;
    @(posedge clk);
    #1;
    tick = 1'b0;
  endtask

  task automatic clear_pkt();
    @(negedge clk);
    fmt_follow = 1'b1;
    @(negedge clk);
    fmt_follow = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 reset pins", det_out, 2'b00);
    chk("R9 drive after reset", det_drv, 2'b11);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fmt_follow = VEC[i][7];
      out_hiz    = VEC[i][6];
      tone_raw   = VEC[i][5:4];
      @(posedge clk);
      #1;
      chk("R9 drive enable", det_drv, VEC[i][1:0]);
      if (!VEC[i][6]) chk("R2 follower copy", det_out, VEC[i][3:2]);
    end
    @(negedge clk);
    out_hiz = 1'b0;
    tone_raw = 2'b00;

    // R3 and R10: ch0 solid tone, ch1 alternating
    clear_pkt();
    chk("R1 packet start low", det_out, 2'b00);
    for (int i = 0; i < 29; i++) step({i[0] == 1'b0, 1'b1}, 1'b1);
    chk("R3 below threshold", det_out, 2'b00);
    step(2'b01, 1'b1);
    chk("R3 respond at 30 / R10 ch1 quiet", det_out, 2'b01);

    // R7: no ticks, changing tone
    for (int i = 0; i < 20; i++) step(2'(i), 1'b0);
    chk("R7 hold without tick", det_out, 2'b01);

    // R6
    for (int i = 0; i < 29; i++) step(2'b00, 1'b1);
    chk("R6 before de-respond", det_out, 2'b01);
    step(2'b00, 1'b1);
    chk("R6 de-respond at 30", det_out, 2'b00);

    // R4: three tone ticks in every four
    clear_pkt();
    for (int i = 0; i < 38; i++) step({1'b0, (i % 4) != 3}, 1'b1);
    chk("R4 gapped 29 tones", det_out, 2'b00);
    step(2'b01, 1'b1);
    chk("R4 gapped 30th tone", det_out, 2'b01);

    // R5: window restart
    clear_pkt();
    for (int i = 0; i < 29; i++) step(2'b01, 1'b1);
    for (int i = 0; i < 11; i++) step(2'b00, 1'b1);
    step(2'b01, 1'b1);
    chk("R5 no carry into new window", det_out, 2'b00);
    for (int i = 0; i < 28; i++) step(2'b01, 1'b1);
    chk("R5 new window 29 tones", det_out, 2'b00);
    step(2'b01, 1'b1);
    chk("R5 new window respond", det_out, 2'b01);

    // R8: format change clears asserted and partial state
    clear_pkt();
    chk("R8 asserted state cleared", det_out, 2'b00);
    for (int i = 0; i < 29; i++) step(2'b11, 1'b1);
    clear_pkt();
    step(2'b11, 1'b1);
    chk("R8 partial count cleared", det_out, 2'b00);

    // R9: release in packet mode, same cycle
    @(negedge clk);
    out_hiz = 1'b1;
    #1;
    chk("R9 release immediate", det_drv, 2'b00);
    @(negedge clk);
    out_hiz = 1'b0;
    #1;
    chk("R9 drive restored", det_drv, 2'b11);

    // R1: reset in the middle of packet activity
    for (int i = 0; i < 29; i++) step(2'b11, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears", det_out, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(2'b11, 1'b1);
    chk("R1 counters zero after reset", det_out, 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule